// File: doc/BRIEF.md
# Reversible Lifting Rotation Stage

This block rotates a pair of signed integer samples by a fixed angle. It does not use cosine and sine multipliers. It uses three lifting steps instead. Each step adds a truncated constant product of one channel to the other channel. The first and third steps use coefficient p and target channel A. The middle step uses coefficient u and targets channel B. The coefficients are integers scaled by 2^CWL and are set as parameters. For an angle α, p is about (cos α − 1)/sin α and u is about sin α.

Every sample carries a direction bit. In the forward direction each step adds its truncated product. In the inverse direction each step subtracts the same truncated product. Because the step pattern p, u, p is symmetric, running the steps in reverse order gives the same p, u, p order again. An inverse pass on the output of a forward pass therefore returns the original integers exactly, whatever rounding happened on the way. The block is a three-stage pipeline with a register after each step. The channel that a step does not modify passes through that stage's register, so both channels stay aligned.

Top module: `lift_rot`

## Requirements
- R1: While rst_n is low, out_valid is 0, and out_a and out_b are 0.
- R2: out_valid equals in_valid from exactly three clock cycles earlier. out_inv equals the in_inv that entered with the same sample.
- R3: With in_inv = 0 (forward), for inputs a, b the block computes a1 = a + T(P·b), then b1 = b + T(U·a1), then a2 = a1 + T(P·b1). It outputs out_a = a2 and out_b = b1. T(x) is x arithmetically shifted right by CWL, which is floor division by 2^CWL in two's complement.
- R4: With in_inv = 1 (inverse), the same three steps subtract instead of add: a1 = a − T(P·b), then b1 = b − T(U·a1), then a2 = a1 − T(P·b1). It outputs out_a = a2 and out_b = b1.
- R5: A forward result fed into a second instance running in inverse mode reproduces the original in_a and in_b bit-exactly. This includes the extreme input values −2^(IW−1) and 2^(IW−1)−1.
- R6: A cycle with in_valid low loads nothing. Three cycles later out_valid is low and out_a and out_b keep their previous values.
- R7: The direction is chosen per sample. Forward and inverse samples can alternate on consecutive cycles and each is computed in its own direction.
- R8: For every input pair within the IW-bit signed range, the GUARD extra bits of internal width keep every intermediate value from overflowing, so outputs match the unbounded-integer formulas of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_inv | input | 1 | Direction: 0 forward, 1 inverse |
| in_a | input | IW | Channel A input, signed |
| in_b | input | IW | Channel B input, signed |
| out_valid | output | 1 | Output sample present |
| out_inv | output | 1 | Direction of the output sample |
| out_a | output | IW+GUARD | Channel A result, signed |
| out_b | output | IW+GUARD | Channel B result, signed |

## Verification
The assertions assume that in_valid and in_inv are driven to known values from reset onward. They also assume that the data inputs stay inside the signed IW-bit range, so the guard bits cover every intermediate sum. The stimulus meets both assumptions: it drives in_valid low during reset and draws every input pair from that range. It includes all pairs of the range extremes, a strided grid over the full range, regular bubbles, and direction bits that change from sample to sample.

// File: rtl/lift_pkg.sv
package lift_pkg;
    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_INV = 1'b1
    } lift_dir_e;

    typedef enum logic {
        TGT_A = 1'b0,
        TGT_B = 1'b1
    } lift_tgt_e;

    localparam int unsigned NUM_STEPS = 3;
endpackage

// File: rtl/lift_mul.sv
module lift_mul #(
    parameter int W    = 12,
    parameter int CFW  = 10,
    parameter int CWL  = 8,
    parameter int COEF = 0
) (
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] y
);
    localparam int PW = W + CFW;
    localparam logic signed [CFW-1:0] C = CFW'(COEF);

    logic signed [PW-1:0] x_ext;
    logic signed [PW-1:0] c_ext;
    logic signed [PW-1:0] full;

    always_comb begin
        x_ext = PW'(x);
        c_ext = PW'(C);
        full  = x_ext * c_ext;
        y     = W'(full >>> CWL);
    end
endmodule

// File: rtl/lift_stage.sv
module lift_stage
    import lift_pkg::*;
#(
    parameter int        W    = 12,
    parameter int        CFW  = 10,
    parameter int        CWL  = 8,
    parameter int        COEF = 0,
    parameter lift_tgt_e TGT  = TGT_A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               v_i,
    input  lift_dir_e          dir_i,
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic               v_o,
    output lift_dir_e          dir_o,
    output logic signed [W-1:0] a_o,
    output logic signed [W-1:0] b_o
);
    logic signed [W-1:0] src;
    logic signed [W-1:0] dst;
    logic signed [W-1:0] delta;
    logic signed [W-1:0] upd;
    logic signed [W-1:0] a_nx;
    logic signed [W-1:0] b_nx;

    generate
        if (TGT == TGT_A) begin : g_tgt_a
            always_comb begin
                src  = b_i;
                dst  = a_i;
                a_nx = upd;
                b_nx = b_i;
            end
        end else begin : g_tgt_b
            always_comb begin
                src  = a_i;
                dst  = b_i;
                a_nx = a_i;
                b_nx = upd;
            end
        end
    endgenerate

    lift_mul #(.W(W), .CFW(CFW), .CWL(CWL), .COEF(COEF)) u_mul (
        .x (src),
        .y (delta)
    );

    always_comb begin
        unique case (dir_i)
            DIR_FWD: upd = dst + delta;
            DIR_INV: upd = dst - delta;
            default: upd = dst;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_o   <= 1'b0;
            dir_o <= DIR_FWD;
            a_o   <= '0;
            b_o   <= '0;
        end else begin
            v_o <= v_i;
            if (v_i) begin
                dir_o <= dir_i;
                a_o   <= a_nx;
                b_o   <= b_nx;
            end
        end
    end
endmodule

// File: rtl/lift_rot.sv
module lift_rot
    import lift_pkg::*;
#(
    parameter int IW    = 10,
    parameter int GUARD = 2,
    parameter int CWL   = 8,
    parameter int CFW   = 10,
    parameter int P_NUM = -106,
    parameter int U_NUM = 181
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_inv,
    input  logic [IW-1:0]        in_a,
    input  logic [IW-1:0]        in_b,
    output logic                 out_valid,
    output logic                 out_inv,
    output logic [IW+GUARD-1:0]  out_a,
    output logic [IW+GUARD-1:0]  out_b
);
    localparam int W = IW + GUARD;
    localparam int N = NUM_STEPS;

    logic                v_s   [N+1];
    lift_dir_e           d_s   [N+1];
    logic signed [W-1:0] a_s   [N+1];
    logic signed [W-1:0] b_s   [N+1];

    always_comb begin
        v_s[0] = in_valid;
        d_s[0] = lift_dir_e'(in_inv);
        a_s[0] = W'($signed(in_a));
        b_s[0] = W'($signed(in_b));
    end

    for (genvar s = 0; s < N; s++) begin : g_step
        localparam int        STEP_COEF = (s == 1) ? U_NUM : P_NUM;
        localparam lift_tgt_e STEP_TGT  = (s == 1) ? TGT_B : TGT_A;
        lift_stage #(
            .W(W), .CFW(CFW), .CWL(CWL), .COEF(STEP_COEF), .TGT(STEP_TGT)
        ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .v_i   (v_s[s]),
            .dir_i (d_s[s]),
            .a_i   (a_s[s]),
            .b_i   (b_s[s]),
            .v_o   (v_s[s+1]),
            .dir_o (d_s[s+1]),
            .a_o   (a_s[s+1]),
            .b_o   (b_s[s+1])
        );
    end

    always_comb begin
        out_valid = v_s[N];
        out_inv   = (d_s[N] == DIR_INV);
        out_a     = a_s[N];
        out_b     = b_s[N];
    end
endmodule

// File: rtl/lift_rot_chk.sv
module lift_rot_chk #(
    parameter int IW = 10,
    parameter int W  = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_inv,
    input logic [IW-1:0] in_a,
    input logic [IW-1:0] in_b,
    input logic          out_valid,
    input logic          out_inv,
    input logic [W-1:0]  out_a,
    input logic [W-1:0]  out_b
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_a == '0 && out_b == '0));

    // R2
    a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R2, R7
    a_r2_dir_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && out_valid) |-> (out_inv == $past(in_inv, 3)));

    // R6
    a_r6_bubble_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && !out_valid) |-> ($stable(out_a) && $stable(out_b)));

    wire unused_ok = &{1'b0, in_a, in_b};
endmodule

bind lift_rot lift_rot_chk #(.IW(IW), .W(IW + GUARD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_inv    (in_inv),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_inv   (out_inv),
    .out_a     (out_a),
    .out_b     (out_b)
);

// File: tb/sim_lift_rot.sv
module sim_lift_rot;
    localparam int IW = 10;
    localparam int GD = 2;
    localparam int W0 = IW + GD;
    localparam int W1 = W0 + GD;
    localparam int CWL = 8;
    localparam longint P = -106;
    localparam longint U = 181;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_inv = 1'b0;
    logic [IW-1:0] in_a = '0;
    logic [IW-1:0] in_b = '0;
    logic out_valid, out_inv;
    logic [W0-1:0] out_a, out_b;
    logic c_valid, c_inv;
    logic [W1-1:0] c_a, c_b;
    logic c_in_valid;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lift_rot #(.IW(IW), .GUARD(GD), .CWL(CWL), .CFW(10), .P_NUM(-106), .U_NUM(181)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inv(in_inv),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_inv(out_inv),
        .out_a(out_a), .out_b(out_b));

    assign c_in_valid = out_valid && !out_inv;

    lift_rot #(.IW(W0), .GUARD(GD), .CWL(CWL), .CFW(10), .P_NUM(-106), .U_NUM(181)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(c_in_valid), .in_inv(1'b1),
        .in_a(out_a), .in_b(out_b), .out_valid(c_valid), .out_inv(c_inv),
        .out_a(c_a), .out_b(c_b));

    longint exp_a_q[$], exp_b_q[$], org_a_q[$], org_b_q[$];
    bit     exp_i_q[$];
    longint last_a = 0, last_b = 0;
    bit     seen = 0;

    function automatic longint tr(longint c, longint x);
        return (c * x) >>> CWL;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sample();
        if (out_valid) begin
            if (exp_a_q.size() == 0) chk("R2 unexpected valid", 1, 0);
            else begin
                longint ea, eb;
                bit ei;
                ea = exp_a_q.pop_front(); eb = exp_b_q.pop_front(); ei = exp_i_q.pop_front();
                chk(ei ? "R4 R7 R8 out_a" : "R3 R7 R8 out_a", longint'($signed(out_a)), ea);
                chk(ei ? "R4 R7 R8 out_b" : "R3 R7 R8 out_b", longint'($signed(out_b)), eb);
                chk("R2 out_inv", longint'(out_inv), longint'(ei));
            end
            last_a = longint'($signed(out_a));
            last_b = longint'($signed(out_b));
            seen = 1;
        end else if (seen) begin
            chk("R6 hold a", longint'($signed(out_a)), last_a);
            chk("R6 hold b", longint'($signed(out_b)), last_b);
        end
        if (c_valid) begin
            if (org_a_q.size() == 0) chk("R5 unexpected valid", 1, 0);
            else begin
                chk("R5 recon a", longint'($signed(c_a)), org_a_q.pop_front());
                chk("R5 recon b", longint'($signed(c_b)), org_b_q.pop_front());
            end
        end
    endtask

    task automatic drive(input bit v, input bit inv, input longint a, input longint b);
        @(negedge clk);
        sample();
        in_valid = v;
        in_inv = inv;
        in_a = IW'(a);
        in_b = IW'(b);
        if (v) begin
            longint a1, b1, a2;
            if (!inv) begin
                a1 = a + tr(P, b); b1 = b + tr(U, a1); a2 = a1 + tr(P, b1);
                org_a_q.push_back(a); org_b_q.push_back(b);
            end else begin
                a1 = a - tr(P, b); b1 = b - tr(U, a1); a2 = a1 - tr(P, b1);
            end
            exp_a_q.push_back(a2); exp_b_q.push_back(b1); exp_i_q.push_back(inv);
        end
    endtask

    initial begin
        longint corner[6];
        int n;
        corner = '{-512, -511, -1, 0, 1, 511};
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", longint'(out_valid), 0);
        chk("R1 out_a in reset", longint'(out_a), 0);
        chk("R1 out_b in reset", longint'(out_b), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                for (int m = 0; m < 2; m++)
                    drive(1'b1, m[0], corner[i], corner[j]);
        n = 0;
        for (longint a = -512; a < 512; a += 23)
            for (longint b = -512; b < 512; b += 29) begin
                n++;
                if (n % 7 == 0) drive(1'b0, 1'b0, 0, 0);
                drive(1'b1, ((n % 3) == 1), a, b);
            end
        repeat (10) drive(1'b0, 1'b0, 0, 0);
        chk("R2 all outputs seen", exp_a_q.size(), 0);
        chk("R5 all reconstructed", org_a_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule